// File: doc/BRIEF.md
# Banked Address Translation Unit

This block maps a 16-bit bus address to a region and a physical offset inside one of three backing stores: graphics storage, work RAM or program storage. The mapping is set by a 5-bit control word and three bank selectors: one for program storage and two for graphics storage. The control word selects one of four program layouts and one of two graphics layouts. It also carries a 2-bit nametable mirroring code, which the block passes straight out.

The logic is purely combinational. A register stage elsewhere holds the control word and the bank selectors, and the outputs follow them in the same cycle. The number of 16 KB program banks and the number of 4 KB graphics banks are parameters. Both must be powers of two. Any bank index is reduced modulo the count that is present, so the index "minus one" always lands on the last bank.

Top module: `bank_xlate`

## Requirements
- R1: The region code is 1 (graphics) for addresses 0x0000–0x1FFF, 0 (unmapped) for 0x2000–0x5FFF, 2 (work RAM) for 0x6000–0x7FFF, and 3 (program) for 0x8000–0xFFFF. Unmapped addresses give offset 0.
- R2: A work RAM address gives offset address − 0x6000.
- R3: A graphics address gives offset bank × 4096 + address[11:0]. Address bit 12 selects window 0 or window 1.
- R4: With ctrl[4] = 0, graphics window 0 uses bank (chr_bank_a with bit 0 cleared) and window 1 uses (chr_bank_a with bit 0 set).
- R5: With ctrl[4] = 1, graphics window 0 uses chr_bank_a and window 1 uses chr_bank_b.
- R6: A program address gives offset bank × 16384 + address[13:0]. Address bit 14 selects window 0 or window 1.
- R7: With ctrl[3:2] equal to 0 or 1, program window 0 uses (prg_bank with bit 0 cleared) and window 1 uses (prg_bank with bit 0 set).
- R8: With ctrl[3:2] = 2, program window 0 is bank 0 and window 1 uses prg_bank.
- R9: With ctrl[3:2] = 3, program window 0 uses prg_bank and window 1 is the last bank, PRG_BANKS − 1.
- R10: Every bank index is taken modulo PRG_BANKS or CHR_BANKS, so the offset never reaches past the storage present.
- R11: The mirror output equals ctrl[1:0]. The codes mean 0 single-screen low, 1 single-screen high, 2 vertical and 3 horizontal.
- R12: All outputs depend only on the present inputs and hold no state, so they are valid in the same cycle as any input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctrl | input | 5 | [4] graphics layout, [3:2] program layout, [1:0] mirroring |
| prg_bank | input | 4 | Program bank selector |
| chr_bank_a | input | 5 | Graphics bank selector for the first window (and for pairs) |
| chr_bank_b | input | 5 | Graphics bank selector for the second window |
| addr | input | 16 | Bus address to translate |
| region | output | 2 | 0 unmapped, 1 graphics, 2 work RAM, 3 program |
| phys_off | output | OFF_W | Physical offset within the selected store |
| mirror | output | 2 | Mirroring code |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register lies between any input and any output. The bench changes inputs just after a rising clock edge and reads the outputs at the following falling edge. It therefore samples half a period after each change and never at an edge. The sweeps cover every layout, every selector value (including values above the bank count) and both windows of each region. Each expected offset is computed by arithmetic modulo the bank count.

// File: rtl/bank_xlate.sv
module bank_xlate #(
  parameter int PRG_BANKS = 8,
  parameter int CHR_BANKS = 16,
  parameter int OFF_W     = 17
) (
  input  logic [4:0]       ctrl,
  input  logic [3:0]       prg_bank,
  input  logic [4:0]       chr_bank_a,
  input  logic [4:0]       chr_bank_b,
  input  logic [15:0]      addr,
  output logic [1:0]       region,
  output logic [OFF_W-1:0] phys_off,
  output logic [1:0]       mirror
);
  localparam int PBW  = $clog2(PRG_BANKS);
  localparam int CBW  = $clog2(CHR_BANKS);
  localparam int PNEED = PBW + 14;
  localparam int CNEED = CBW + 12;

  localparam logic [1:0] RG_NONE = 2'd0;
  localparam logic [1:0] RG_GFX  = 2'd1;
  localparam logic [1:0] RG_WRAM = 2'd2;
  localparam logic [1:0] RG_PRG  = 2'd3;

  if (OFF_W < PNEED || OFF_W < CNEED || OFF_W < 13) begin : g_width_bad
    $error("OFF_W too narrow for the configured bank counts");
  end

  wire chr_win = addr[12];
  wire prg_win = addr[14];

  logic [4:0] chr_idx;
  logic [3:0] prg_idx;

  always_comb begin
    if (ctrl[4]) chr_idx = chr_win ? chr_bank_b : chr_bank_a;
    else         chr_idx = {chr_bank_a[4:1], chr_win};
  end

  always_comb begin
    case (ctrl[3:2])
      2'd2:    prg_idx = prg_win ? prg_bank : 4'd0;
      2'd3:    prg_idx = prg_win ? 4'hF : prg_bank;
      default: prg_idx = {prg_bank[3:1], prg_win};
    endcase
  end

  wire [PBW-1:0]   prg_sel = PBW'(prg_idx);
  wire [CBW-1:0]   chr_sel = CBW'(chr_idx);
  wire [PNEED-1:0] prg_off = {prg_sel, addr[13:0]};
  wire [CNEED-1:0] chr_off = {chr_sel, addr[11:0]};

  always_comb begin
    if (addr[15]) begin
      region   = RG_PRG;
      phys_off = OFF_W'(prg_off);
    end else if (addr[14:13] == 2'b11) begin
      region   = RG_WRAM;
      phys_off = OFF_W'(addr[12:0]);
    end else if (addr[14:13] == 2'b00) begin
      region   = RG_GFX;
      phys_off = OFF_W'(chr_off);
    end else begin
      region   = RG_NONE;
      phys_off = '0;
    end
  end

  assign mirror = ctrl[1:0];
endmodule

// File: rtl/bank_xlate_chk.sv
module bank_xlate_chk #(
  parameter int PRG_BANKS = 8,
  parameter int CHR_BANKS = 16,
  parameter int OFF_W     = 17
) (
  input logic [4:0]       ctrl,
  input logic [3:0]       prg_bank,
  input logic [4:0]       chr_bank_a,
  input logic [4:0]       chr_bank_b,
  input logic [15:0]      addr,
  input logic [1:0]       region,
  input logic [OFF_W-1:0] phys_off,
  input logic [1:0]       mirror
);
  wire known = !$isunknown({ctrl, prg_bank, chr_bank_a, chr_bank_b, addr});
  wire [31:0] off32 = 32'(phys_off);

  always_comb begin
    if (known) begin
      // R1
      region_map_chk: assert (region == (addr < 16'h2000 ? 2'd1 :
                                         addr < 16'h6000 ? 2'd0 :
                                         addr < 16'h8000 ? 2'd2 : 2'd3));
      // R2
      wram_off_chk: assert (region != 2'd2 || off32 == 32'(addr) - 32'h6000);
      // R6
      prg_low_chk: assert (region != 2'd3 || off32[13:0] == addr[13:0]);
      // R8
      fixed_first_chk: assert (!(region == 2'd3 && ctrl[3:2] == 2'd2 && !addr[14])
                               || off32 < 32'd16384);
      // R9
      fixed_last_chk: assert (!(region == 2'd3 && ctrl[3:2] == 2'd3 && addr[14])
                              || (off32 >> 14) == 32'(PRG_BANKS - 1));
      // R10
      prg_bound_chk: assert (region != 2'd3 || off32 < 32'(PRG_BANKS) * 32'd16384);
      // R10
      chr_bound_chk: assert (region != 2'd1 || off32 < 32'(CHR_BANKS) * 32'd4096);
      // R1
      unmapped_zero_chk: assert (region != 2'd0 || off32 == 32'd0);
    end
  end
endmodule

bind bank_xlate bank_xlate_chk #(
  .PRG_BANKS(PRG_BANKS), .CHR_BANKS(CHR_BANKS), .OFF_W(OFF_W)
) u_chk (
  .ctrl(ctrl), .prg_bank(prg_bank), .chr_bank_a(chr_bank_a), .chr_bank_b(chr_bank_b),
  .addr(addr), .region(region), .phys_off(phys_off), .mirror(mirror)
);

// File: tb/tb_bank_xlate.sv
module tb_bank_xlate;
  localparam int PB = 8;
  localparam int CB = 16;
  localparam int OW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]    ctrl = '0;
  logic [3:0]    prg_bank = '0;
  logic [4:0]    chr_bank_a = '0;
  logic [4:0]    chr_bank_b = '0;
  logic [15:0]   addr = '0;
  logic [1:0]    region;
  logic [OW-1:0] phys_off;
  logic [1:0]    mirror;

  bank_xlate #(.PRG_BANKS(PB), .CHR_BANKS(CB), .OFF_W(OW)) dut (
    .ctrl(ctrl), .prg_bank(prg_bank), .chr_bank_a(chr_bank_a), .chr_bank_b(chr_bank_b),
    .addr(addr), .region(region), .phys_off(phys_off), .mirror(mirror)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (ctrl=%h prg=%h a=%h b=%h addr=%h)",
               req, act, exp, ctrl, prg_bank, chr_bank_a, chr_bank_b, addr);
    end
  endtask

  task automatic drive(logic [4:0] c, logic [3:0] p, logic [4:0] a, logic [4:0] b, logic [15:0] ad);
    @(posedge clk);
    #1;
    ctrl = c; prg_bank = p; chr_bank_a = a; chr_bank_b = b; addr = ad;
    @(negedge clk);
  endtask

  function automatic int exp_region(int ad);
    if (ad < 'h2000) return 1;
    if (ad < 'h6000) return 0;
    if (ad < 'h8000) return 2;
    return 3;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    drive(5'd0, 4'd0, 5'd0, 5'd0, 16'h0000);
    chk("R1 idle region", region, 1);
    chk("R3 idle offset", phys_off, 0);

    for (int ad = 0; ad < 'h10000; ad += 'h100) begin
      drive(5'b01100, 4'd0, 5'd0, 5'd0, 16'(ad + 'h5A));
      chk("R1 region", region, exp_region(ad));
      if (exp_region(ad) == 0) chk("R1 unmapped offset", phys_off, 0);
      if (exp_region(ad) == 2) chk("R2 wram offset", phys_off, ad + 'h5A - 'h6000);
    end

    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 32; a++)
        for (int b = 0; b < 32; b++)
          for (int w = 0; w < 2; w++) begin
            int bank;
            int low;
            low = (a * 37 + b * 11 + w * 5) & 'hFFF;
            drive(5'(m << 4), 4'd0, 5'(a), 5'(b), 16'((w << 12) | low));
            if (m == 0) bank = w ? (a | 1) : (a & 'h1E);
            else        bank = w ? b : a;
            bank = bank % CB;
            chk(m == 0 ? "R4 R3 R10 gfx paired" : "R5 R3 R10 gfx split",
                phys_off, bank * 4096 + low);
          end

    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 16; p++)
        for (int w = 0; w < 2; w++) begin
          int bank;
          int low;
          low = (p * 1031 + w * 77 + m) & 'h3FFF;
          drive(5'(m << 2), 4'(p), 5'd0, 5'd0, 16'('h8000 | (w << 14) | low));
          case (m)
            2:       bank = w ? p : 0;
            3:       bank = w ? PB - 1 : p;
            default: bank = w ? (p | 1) : (p & 'hE);
          endcase
          bank = bank % PB;
          chk(m < 2 ? "R7 R6 R10 prg pair" : (m == 2 ? "R8 R6 prg fixed first" : "R9 R6 prg fixed last"),
              phys_off, bank * 16384 + low);
          chk("R1 prg region", region, 3);
        end

    for (int c = 0; c < 32; c++) begin
      drive(5'(c), 4'd5, 5'd3, 5'd9, 16'h1234);
      chk("R11 mirror", mirror, c & 3);
    end

    @(posedge clk);
    #1;
    ctrl = 5'b11100; prg_bank = 4'd6; addr = 16'h8123;
    #1;
    chk("R12 same-cycle update", phys_off, 6 * 16384 + 'h123);
    ctrl = 5'b11000;
    #1;
    chk("R12 same-cycle mode change", phys_off, 'h123);

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule